// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block is the multi-cycle control unit that a small 16-bit processor core hands its call and return operations to. After decoding, the core presents one of five operations together with the address of the current instruction, the stack pointer, the 8-bit flag register, a 16-bit register operand and a 16-bit immediate. It then pulses `start`. The sequencer performs the stack pushes, stack pops and pointer-table read over a plain word-wide memory port. When the operation completes it presents the updated program counter, stack pointer and flags.

The operation codes are fixed:

| Code | Operation |
|------|-----------|
| 0 | Call through a register |
| 1 | Call to a 16-bit absolute address |
| 2 | Call through a pointer word at an 8-bit address |
| 3 | Subroutine return |
| 4 | Exception return |

Codes 5 to 7 are undefined. Each operation occupies the block for a fixed number of cycles, so the core's timing stays exact. Memory addresses are byte addresses, and every access moves one 16-bit word. Read data is returned by the memory one cycle after the read strobe.

Top module: `callret_seq`

## Requirements
- R1: A call (codes 0, 1, 2) first lowers SP by 2, then writes the return address to the word at the lowered SP, and finally loads PC with the target.
- R2: The return address is `pc_in + 2` for codes 0 and 2, and `pc_in + 4` for code 1, with 16-bit wraparound.
- R3: Code 0 takes its target from `reg_in` and keeps `busy` high for exactly 6 cycles.
- R4: Code 1 takes its target from `imm_in` and keeps `busy` high for exactly 8 cycles.
- R5: Code 2 reads its target from the word at byte address `imm_in[7:0]` zero-extended to 16 bits, so `imm_in[15:8]` has no effect. It keeps `busy` high for exactly 8 cycles.
- R6: Code 3 loads PC from the word at SP, then raises SP by 2. It keeps `busy` high for exactly 8 cycles.
- R7: Code 4 loads the flags from bits 7:0 of the word at SP, ignoring bits 15:8, and raises SP by 2. It then loads PC from the word at the new SP and raises SP by 2 again. It keeps `busy` high for exactly 10 cycles.
- R8: Codes 0 to 3 leave the flag output equal to `ccr_in`.
- R9: `start` is accepted only while `busy` is low and the code is 0 to 4. `busy` rises the cycle after acceptance. `done` is high for exactly the one cycle after `busy` falls, and results are valid from that cycle. `start` while busy, or with codes 5 to 7, has no effect.
- R10: While reset is held, `busy`, `done`, `mem_rd` and `mem_wr` are low, and PC, SP and flag outputs are zero.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle, and both are low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code |
| pc_in | input | 16 | Address of the current instruction |
| sp_in | input | 16 | Stack pointer before the operation |
| ccr_in | input | 8 | Flags before the operation |
| reg_in | input | 16 | Register operand (target for code 0) |
| imm_in | input | 16 | Immediate (target for code 1, pointer address in bits 7:0 for code 2) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |
| ccr_out | output | 8 | Resulting flags |
| mem_addr | output | 16 | Byte address of the word access |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |

## Verification
The bench builds the block with its defaults: a 16-bit data path, 8-bit flags, an 8-bit pointer field, cycle budgets of 6, 8, 8, 8 and 10, and instruction lengths of 2 and 4 bytes. At these sizes a stack pointer of 0x0002 or 0xFFFE and an instruction address of 0xFFFE can be driven directly, so the wraparound of both SP and the return address is exercised. Because the pointer field is exactly one byte narrower than the address, a pointer immediate with a nonzero high byte shows whether the zero-extension holds. A full-ones flag word and a flag word with a nonzero high byte cover the byte masking on exception return.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [2:0] {
    OP_JREG = 3'd0,
    OP_JABS = 3'd1,
    OP_JIND = 3'd2,
    OP_RET  = 3'd3,
    OP_RTE  = 3'd4
  } crs_op_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_is_call(input logic [2:0] code);
    return (code == OP_JREG) || (code == OP_JABS) || (code == OP_JIND);
  endfunction

endpackage

// File: rtl/crs_timer.sv
module crs_timer
  import callret_pkg::*;
#(
  parameter int CYC_JREG = 6,
  parameter int CYC_JABS = 8,
  parameter int CYC_JIND = 8,
  parameter int CYC_RET  = 8,
  parameter int CYC_RTE  = 10,
  parameter int SW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          last,
  output logic [SW-1:0] step,
  output crs_op_e       op_q
);

  int budget;

  always_comb begin
    case (op_q)
      OP_JREG: budget = CYC_JREG;
      OP_JABS: budget = CYC_JABS;
      OP_JIND: budget = CYC_JIND;
      OP_RET:  budget = CYC_RET;
      default: budget = CYC_RTE;
    endcase
  end

  assign accept = start && !busy && op_known(op);
  assign last   = busy && (step == SW'(budget - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      step <= '0;
      op_q <= OP_JREG;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
        op_q <= crs_op_e'(op);
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
  import callret_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int PW        = 8,
  parameter int SW        = 4,
  parameter int LEN_SHORT = 2,
  parameter int LEN_LONG  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          busy,
  input  logic          last,
  input  logic [SW-1:0] step,
  input  crs_op_e       op_q,
  input  logic [2:0]    op,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [CW-1:0] ccr_in,
  input  logic [DW-1:0] reg_in,
  input  logic [DW-1:0] imm_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic [CW-1:0] ccr_out,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata
);

  localparam logic [DW-1:0] WORD_STEP = DW'(DW / 8);

  logic [DW-1:0] tgt_q;
  logic [DW-1:0] ret_q;
  logic [PW-1:0] ptr_q;
  logic [DW-1:0] ptr_addr;

  assign ptr_addr = {{(DW-PW){1'b0}}, ptr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out    <= '0;
      sp_out    <= '0;
      ccr_out   <= '0;
      tgt_q     <= '0;
      ret_q     <= '0;
      ptr_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      if (accept) begin
        pc_out  <= pc_in;
        sp_out  <= sp_in;
        ccr_out <= ccr_in;
        ptr_q   <= imm_in[PW-1:0];
        tgt_q   <= (op == OP_JABS) ? imm_in : reg_in;
        ret_q   <= pc_in + ((op == OP_JABS) ? DW'(LEN_LONG) : DW'(LEN_SHORT));
      end else if (busy) begin
        if (op_is_call(op_q)) begin
          if (step == SW'(0)) sp_out <= sp_out - WORD_STEP;
          if (step == SW'(1)) begin
            mem_wr    <= 1'b1;
            mem_addr  <= sp_out;
            mem_wdata <= ret_q;
          end
          if (op_q == OP_JIND && step == SW'(2)) begin
            mem_rd   <= 1'b1;
            mem_addr <= ptr_addr;
          end
          if (op_q == OP_JIND && step == SW'(4)) tgt_q <= mem_rdata;
        end else if (op_q == OP_RET) begin
          if (step == SW'(0)) begin
            mem_rd   <= 1'b1;
            mem_addr <= sp_out;
          end
          if (step == SW'(2)) begin
            tgt_q  <= mem_rdata;
            sp_out <= sp_out + WORD_STEP;
          end
        end else begin
          if (step == SW'(0) || step == SW'(3)) begin
            mem_rd   <= 1'b1;
            mem_addr <= sp_out;
          end
          if (step == SW'(2)) begin
            ccr_out <= mem_rdata[CW-1:0];
            sp_out  <= sp_out + WORD_STEP;
          end
          if (step == SW'(5)) begin
            tgt_q  <= mem_rdata;
            sp_out <= sp_out + WORD_STEP;
          end
        end
        if (last) pc_out <= tgt_q;
      end
    end
  end

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int PW        = 8,
  parameter int LEN_SHORT = 2,
  parameter int LEN_LONG  = 4,
  parameter int CYC_JREG  = 6,
  parameter int CYC_JABS  = 8,
  parameter int CYC_JIND  = 8,
  parameter int CYC_RET   = 8,
  parameter int CYC_RTE   = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] sp_in,
  input  logic [CW-1:0] ccr_in,
  input  logic [DW-1:0] reg_in,
  input  logic [DW-1:0] imm_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] sp_out,
  output logic [CW-1:0] ccr_out,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int CYC_MAX = (CYC_RTE > CYC_JABS) ? CYC_RTE : CYC_JABS;
  localparam int SW      = $clog2(CYC_MAX + 1);

  logic          accept;
  logic          last;
  logic [SW-1:0] step;
  crs_op_e       op_q;

  crs_timer #(
    .CYC_JREG(CYC_JREG), .CYC_JABS(CYC_JABS), .CYC_JIND(CYC_JIND),
    .CYC_RET(CYC_RET), .CYC_RTE(CYC_RTE), .SW(SW)
  ) u_timer (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .accept(accept), .busy(busy), .done(done), .last(last),
    .step(step), .op_q(op_q)
  );

  crs_datapath #(
    .DW(DW), .CW(CW), .PW(PW), .SW(SW),
    .LEN_SHORT(LEN_SHORT), .LEN_LONG(LEN_LONG)
  ) u_path (
    .clk(clk), .rst(rst), .accept(accept), .busy(busy), .last(last),
    .step(step), .op_q(op_q), .op(op),
    .pc_in(pc_in), .sp_in(sp_in), .ccr_in(ccr_in), .reg_in(reg_in),
    .imm_in(imm_in), .mem_rdata(mem_rdata),
    .pc_out(pc_out), .sp_out(sp_out), .ccr_out(ccr_out),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk
  import callret_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int PW       = 8,
  parameter int CYC_JREG = 6,
  parameter int CYC_JABS = 8,
  parameter int CYC_JIND = 8,
  parameter int CYC_RET  = 8,
  parameter int CYC_RTE  = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic          busy,
  input logic          done,
  input logic [2:0]    op_q,
  input logic [CW-1:0] ccr_out,
  input logic [DW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr
);

  int busy_cnt;
  int expect_cyc;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= 0;
    else              busy_cnt <= busy_cnt + 1;
  end

  always_comb begin
    case (op_q)
      3'd0:    expect_cyc = CYC_JREG;
      3'd1:    expect_cyc = CYC_JABS;
      3'd2:    expect_cyc = CYC_JIND;
      3'd3:    expect_cyc = CYC_RET;
      default: expect_cyc = CYC_RTE;
    endcase
  end

  AST_ACCEPT_BUSY:  assert property (@(posedge clk) disable iff (rst) accept |=> busy); // R9
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R9
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  // budgets per code also cover R4, R5, R6 and R7
  AST_BUDGET:       assert property (@(posedge clk) disable iff (rst) done |-> busy_cnt == expect_cyc); // R3
  AST_RDWR_EXCL:    assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R11
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_rd && !mem_wr); // R11
  AST_WR_CALL_ONLY: assert property (@(posedge clk) disable iff (rst) mem_wr |-> op_is_call(op_q)); // R1
  AST_PTR_LOW:      assert property (@(posedge clk) disable iff (rst)
                      (mem_rd && op_q == 3'd2) |-> mem_addr[DW-1:PW] == '0); // R5
  AST_FLAGS_HELD:   assert property (@(posedge clk) disable iff (rst)
                      ($past(busy) && op_q != 3'd4) |-> $stable(ccr_out)); // R8

endmodule

bind callret_seq callret_seq_chk #(
  .DW(DW), .CW(CW), .PW(PW),
  .CYC_JREG(CYC_JREG), .CYC_JABS(CYC_JABS), .CYC_JIND(CYC_JIND),
  .CYC_RET(CYC_RET), .CYC_RTE(CYC_RTE)
) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .busy(busy), .done(done),
  .op_q(op_q), .ccr_out(ccr_out), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/callret_seq_test.sv
module callret_seq_test;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] pc;
    logic [15:0] sp;
    logic [7:0]  ccr;
    logic [15:0] rg;
    logic [15:0] imm;
    logic [15:0] xpc;
    logic [15:0] xsp;
    logic [7:0]  xccr;
    logic [15:0] xret;
    logic [4:0]  xcyc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h1000, 16'h0400, 8'h5A, 16'h2222, 16'h0000, 16'h2222, 16'h03FE, 8'h5A, 16'h1002, 5'd6},
    '{3'd1, 16'h1100, 16'h0400, 8'h81, 16'h0000, 16'h3456, 16'h3456, 16'h03FE, 8'h81, 16'h1104, 5'd8},
    '{3'd2, 16'h1200, 16'h0410, 8'h00, 16'h0000, 16'hFF40, 16'h2468, 16'h040E, 8'h00, 16'h1202, 5'd8},
    '{3'd3, 16'h9998, 16'h0200, 8'h3C, 16'h0000, 16'h0000, 16'h1234, 16'h0202, 8'h3C, 16'h0000, 5'd8},
    '{3'd4, 16'h7770, 16'h0300, 8'h00, 16'h0000, 16'h0000, 16'h4566, 16'h0304, 8'hC3, 16'h0000, 5'd10},
    '{3'd0, 16'hFFFE, 16'h0002, 8'h77, 16'h0100, 16'h0000, 16'h0100, 16'h0000, 8'h77, 16'h0000, 5'd6},
    '{3'd3, 16'h0010, 16'hFFFE, 8'hE1, 16'h0000, 16'h0000, 16'h0ABC, 16'h0000, 8'hE1, 16'h0000, 5'd8},
    '{3'd4, 16'h0020, 16'h0310, 8'h12, 16'h0000, 16'h0000, 16'h0000, 16'h0314, 8'hFF, 16'h0000, 5'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] pc_in = '0, sp_in = '0, reg_in = '0, imm_in = '0;
  logic [7:0]  ccr_in = '0;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] pc_out, sp_out, mem_addr, mem_wdata;
  logic [7:0]  ccr_out;
  logic [15:0] mem_rdata = '0;

  logic        pl_we = 1'b0;
  logic [15:0] pl_a = '0, pl_d = '0;
  logic [15:0] ram [1024];
  logic [15:0] last_rd = '0;

  int ntot = 0;
  int nbad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  callret_seq uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .pc_in(pc_in),
    .sp_in(sp_in), .ccr_in(ccr_in), .reg_in(reg_in), .imm_in(imm_in),
    .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
    .ccr_out(ccr_out), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (pl_we) ram[pl_a[10:1]] <= pl_d;
    else if (mem_wr) ram[mem_addr[10:1]] <= mem_wdata;
    if (mem_rd) begin
      mem_rdata <= ram[mem_addr[10:1]];
      last_rd   <= mem_addr;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_a = a; pl_d = d;
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    op = v.op; pc_in = v.pc; sp_in = v.sp; ccr_in = v.ccr;
    reg_in = v.rg; imm_in = v.imm;
  endtask

  task automatic run_op(input vec_t v, output int cyc);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      ntot++; nbad++;
      $display("FAIL R9 watchdog: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    int cyc;
    vec_t w;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy", 16'(busy), 16'h0);
    chk("R10 done", 16'(done), 16'h0);
    chk("R10 mem strobes", 16'({mem_rd, mem_wr}), 16'h0);
    chk("R10 pc", pc_out, 16'h0);
    chk("R10 sp", sp_out, 16'h0);
    chk("R10 ccr", 16'(ccr_out), 16'h0);
    rst = 1'b0;

    poke(16'h0040, 16'h2468);
    poke(16'h0200, 16'h1234);
    poke(16'h0300, 16'hA5C3);
    poke(16'h0302, 16'h4566);
    poke(16'h0310, 16'h00FF);
    poke(16'h0312, 16'h0000);
    poke(16'h0000, 16'hBEEF);
    poke(16'hFFFE, 16'h0ABC);

    for (int i = 0; i < NV; i++) begin
      w = VECS[i];
      run_op(w, cyc);
      // R3 R4 R5 R6 R7 cycle budgets
      chk($sformatf("R3 R4 R5 R6 R7 cycles v%0d", i), 16'(cyc), 16'(w.xcyc));
      chk($sformatf("R9 done v%0d", i), 16'(done), 16'h1);
      chk($sformatf("R1 R6 R7 pc v%0d", i), pc_out, w.xpc);
      chk($sformatf("R1 R6 R7 sp v%0d", i), sp_out, w.xsp);
      chk($sformatf("R7 R8 ccr v%0d", i), 16'(ccr_out), 16'(w.xccr));
      if (w.op <= 3'd2)
        chk($sformatf("R1 R2 pushed word v%0d", i), ram[w.xsp[10:1]], w.xret);
      if (w.op == 3'd2)
        chk("R5 pointer address", last_rd, 16'h0040);
      @(negedge clk);
      chk($sformatf("R9 done pulse v%0d", i), 16'(done), 16'h0);
    end

    // R9: undefined code is ignored
    @(negedge clk);
    op = 3'd6; pc_in = 16'h5555; sp_in = 16'h0600; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 undefined code busy", 16'(busy), 16'h0);
    @(negedge clk);
    chk("R9 undefined code pc", pc_out, 16'h0000);
    chk("R9 undefined code sp", sp_out, 16'h0314);

    // R9: start while busy is ignored
    @(negedge clk);
    op = 3'd0; pc_in = 16'h2000; sp_in = 16'h0500; ccr_in = 8'h11;
    reg_in = 16'h0777; imm_in = 16'h0000; start = 1'b1;
    @(negedge clk);
    op = 3'd3; pc_in = 16'h3000; sp_in = 16'h0200; ccr_in = 8'h99;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    while (busy && cyc < 40) begin
      @(negedge clk);
      if (busy) cyc++;
    end
    chk("R9 busy-start cycles", 16'(cyc), 16'd6);
    chk("R9 busy-start pc", pc_out, 16'h0777);
    chk("R9 busy-start sp", sp_out, 16'h04FE);
    chk("R9 busy-start ccr", 16'(ccr_out), 16'h11);
    chk("R2 busy-start pushed", ram[16'h04FE >> 1], 16'h2002);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

endmodule